// File: doc/BRIEF.md
# Allocation Tag Generator and Tagged Pointer Arithmetic Unit

This unit serves a processor's memory-tagging datapath. Pointers are 64 bits wide. The low 56 bits hold the address. Bits 59:56 carry a 4-bit tag that keys the pointer to the memory it may touch. Bits 63:60 pass through untouched. The unit performs six operations, all selected by an operation code:

- It draws a random tag from a 16-bit linear feedback shift register (LFSR), steers it away from any value in a software-supplied exclusion mask, and writes it into the tag field of a pointer.
- It folds a pointer's tag into an exclusion mask.
- It offsets a pointer's address and tag independently by two immediates.
- It subtracts two pointers over their 56-bit address fields only, with or without setting condition flags.

The generator has two modes. In the reproducible mode it advances only on tag requests, so a loaded seed replays the same tag sequence. In the free-running mode it advances every clock cycle, so its state also depends on request timing.

Every result is registered. A request presented in one cycle produces its result in the next. Instruction decode and register files sit outside this unit.

Top module: `tagu_top`

## Requirements
- R1: While rst_ni is low, res_valid_o, res_data_o and flags_o are all 0.
- R2: Operation codes on req_op_i are 0 random tag, 1 exclusion add, 2 tag add, 3 tag subtract, 4 pointer subtract, 5 pointer subtract with flags. A valid request with code 0 to 5 raises res_valid_o one cycle later and loads res_data_o. Codes 6 and 7, or no request, give res_valid_o = 0, and res_data_o holds its value.
- R3: Random tag: the result is opnd_a_i with bits 59:56 replaced by the picked tag. The candidate is the LFSR's low nibble, taken before the LFSR steps. The picked tag is the first value at or above the candidate, counting upward modulo 16, whose bit in opnd_b_i[15:0] is clear. If all 16 bits are set, the picked tag is 0.
- R4: The LFSR resets to 16'hACE1. One step shifts the state right by one and, if the bit shifted out was 1, XORs in 16'hB400. With free_run_i = 0 it steps once per random-tag request. With free_run_i = 1 it steps every clock cycle.
- R5: When seed_load_i is high, the next LFSR state is seed_i, or 16'hACE1 if seed_i is 0. A seed load takes priority over stepping. A random-tag request in the same cycle uses the old state.
- R6: Exclusion add: the result is {48'b0, opnd_b_i[15:0] with bit opnd_a_i[59:56] set}.
- R7: Tag add: the address bits 55:0 become address + 16*addr_imm_i, modulo 2^56. If tag_imm_i is 0, the tag is unchanged. Otherwise the tag is (tag + tag_imm_i) mod 16, moved up past excluded values by the R3 rule, using the mask in opnd_b_i[15:0]. Bits 63:60 are kept.
- R8: Tag subtract: the address becomes address - 16*addr_imm_i, modulo 2^56. The tag follows R7, starting from (tag - tag_imm_i) mod 16.
- R9: Pointer subtract: the result is the 56-bit difference opnd_a_i[55:0] - opnd_b_i[55:0], sign-extended from bit 55. Bits 63:56 of either operand have no effect.
- R10: Pointer subtract with flags gives the R9 result and loads flags_o = {N,Z,C,V}, bit 3 down to bit 0. The flags are those of a 64-bit subtract x - y, where x and y are the operands' 56-bit address fields sign-extended to 64 bits. N is the sign of the difference, Z is set when the difference is zero, C is set when there is no borrow, and V is set on signed overflow.
- R11: flags_o changes only on a valid request with code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Operation code |
| opnd_a_i | input | 64 | Pointer operand |
| opnd_b_i | input | 64 | Exclusion mask in bits 15:0, or second pointer |
| addr_imm_i | input | 6 | Address offset in 16-byte granules |
| tag_imm_i | input | 4 | Tag offset |
| seed_load_i | input | 1 | Load seed_i into the LFSR |
| seed_i | input | 16 | Seed value |
| free_run_i | input | 1 | Step the LFSR every cycle |
| res_valid_o | output | 1 | Result valid |
| res_data_o | output | 64 | Result |
| flags_o | output | 4 | N, Z, C, V |

## Verification
Each result, and each flag update, is due exactly one clock cycle after its request. The bench drives every request on a falling edge and compares res_valid_o, res_data_o and flags_o on the next falling edge, every cycle, against a behavioural model. The LFSR changes at the same edge that captures the request, so its effect shows on the result of the next random-tag request. The model therefore advances its own generator state once per cycle, in step with the design, including free-running cycles and seed loads.

// File: rtl/tagu_pkg.sv
package tagu_pkg;
  localparam int TAG_W   = 4;
  localparam int ADDR_W  = 56;
  localparam int PTR_W   = 64;
  localparam int LFSR_W  = 16;
  localparam int IMM_W   = 6;
  localparam int GRAN_SH = 4;

  typedef enum logic [2:0] {
    OP_RAND  = 3'd0,
    OP_EXCL  = 3'd1,
    OP_ADDT  = 3'd2,
    OP_SUBT  = 3'd3,
    OP_PSUB  = 3'd4,
    OP_PSUBF = 3'd5
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/tagu_lfsr.sv
module tagu_lfsr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] INIT = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_step;

  assign state_step = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= INIT;
    else if (load_i)  state_q <= (seed_i == '0) ? INIT : seed_i;
    else if (step_i)  state_q <= state_step;
  end

  assign state_o = state_q;

  a_r4_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  a_r5_seed_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i != '0) |=> state_q == $past(seed_i));
  a_r5_zero_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i == '0) |=> state_q == INIT);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(state_q));
endmodule

// File: rtl/tagu_tag_pick.sv
module tagu_tag_pick #(
  parameter int W = 4,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] cand_i,
  input  logic [N-1:0] excl_i,
  output logic [W-1:0] tag_o
);
  logic [W-1:0] idx [N];
  logic [N-1:0] free;

  for (genvar gi = 0; gi < N; gi++) begin : g_scan
    assign idx[gi]  = cand_i + W'(gi);
    assign free[gi] = ~excl_i[idx[gi]];
  end

  // nearest free value at or above the candidate; all excluded -> 0
  always_comb begin
    tag_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free[i]) tag_o = idx[i];
    end
  end
endmodule

// File: rtl/tagu_arith.sv
module tagu_arith
  import tagu_pkg::*;
#(
  parameter int PW = PTR_W,
  parameter int AW = ADDR_W,
  parameter int TW = TAG_W,
  parameter int IW = IMM_W,
  localparam int NT = 1 << TW
) (
  input  op_e           op_i,
  input  logic [PW-1:0] a_i,
  input  logic [PW-1:0] b_i,
  input  logic [IW-1:0] addr_imm_i,
  input  logic [TW-1:0] tag_imm_i,
  output logic [PW-1:0] res_o,
  output flags_t        flags_o
);
  localparam int TOP_W = PW - AW - TW;

  logic [AW-1:0] addr, imm_bytes, addr_new, diff;
  logic [TW-1:0] tag_in, cand, off_tag, tag_new;
  logic [NT-1:0] mask;
  logic [PW-1:0] x, y, r;
  logic [PW:0]   wide;
  logic          unused_b_top;

  assign addr      = a_i[AW-1:0];
  assign tag_in    = a_i[AW+TW-1:AW];
  assign mask      = b_i[NT-1:0];
  assign imm_bytes = AW'({addr_imm_i, {GRAN_SH{1'b0}}});
  assign addr_new  = (op_i == OP_SUBT) ? addr - imm_bytes : addr + imm_bytes;
  assign cand      = (op_i == OP_SUBT) ? tag_in - tag_imm_i : tag_in + tag_imm_i;

  tagu_tag_pick #(.W(TW)) u_off_pick (
    .cand_i (cand),
    .excl_i (mask),
    .tag_o  (off_tag)
  );

  assign tag_new = (tag_imm_i == '0) ? tag_in : off_tag;

  assign diff = a_i[AW-1:0] - b_i[AW-1:0];
  assign x    = {{(PW-AW){a_i[AW-1]}}, a_i[AW-1:0]};
  assign y    = {{(PW-AW){b_i[AW-1]}}, b_i[AW-1:0]};
  assign wide = {1'b0, x} - {1'b0, y};
  assign r    = wide[PW-1:0];

  assign flags_o.n = r[PW-1];
  assign flags_o.z = (r == '0);
  assign flags_o.c = ~wide[PW];
  assign flags_o.v = (x[PW-1] ^ y[PW-1]) & (r[PW-1] ^ x[PW-1]);

  assign unused_b_top = ^b_i[PW-1:AW];

  always_comb begin
    unique case (op_i)
      OP_EXCL:          res_o = PW'(mask | (NT'(1) << tag_in));
      OP_ADDT, OP_SUBT: res_o = {a_i[PW-1:PW-TOP_W], tag_new, addr_new};
      OP_PSUB, OP_PSUBF: res_o = {{(PW-AW){diff[AW-1]}}, diff};
      default:          res_o = a_i;
    endcase
  end
endmodule

// File: rtl/tagu_top.sv
module tagu_top
  import tagu_pkg::*;
#(
  parameter int PW = PTR_W,
  parameter int AW = ADDR_W,
  parameter int TW = TAG_W,
  parameter int IW = IMM_W,
  parameter int LW = LFSR_W,
  localparam int NT = 1 << TW,
  localparam int TLSB = AW,
  localparam int TMSB = AW + TW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [2:0]    req_op_i,
  input  logic [PW-1:0] opnd_a_i,
  input  logic [PW-1:0] opnd_b_i,
  input  logic [IW-1:0] addr_imm_i,
  input  logic [TW-1:0] tag_imm_i,
  input  logic          seed_load_i,
  input  logic [LW-1:0] seed_i,
  input  logic          free_run_i,
  output logic          res_valid_o,
  output logic [PW-1:0] res_data_o,
  output logic [3:0]    flags_o
);
  op_e           op;
  logic          op_ok, fire, rand_req;
  logic [LW-1:0] lfsr_state;
  logic [TW-1:0] rand_tag;
  logic [PW-1:0] arith_res, res_nxt;
  flags_t        arith_flags, flags_q;

  assign op       = op_e'(req_op_i);
  assign op_ok    = (req_op_i <= 3'(OP_PSUBF));
  assign fire     = req_valid_i && op_ok;
  assign rand_req = req_valid_i && (op == OP_RAND);

  tagu_lfsr #(.W(LW)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (rand_req || free_run_i),
    .load_i  (seed_load_i),
    .seed_i  (seed_i),
    .state_o (lfsr_state)
  );

  tagu_tag_pick #(.W(TW)) u_rand_pick (
    .cand_i (lfsr_state[TW-1:0]),
    .excl_i (opnd_b_i[NT-1:0]),
    .tag_o  (rand_tag)
  );

  tagu_arith #(.PW(PW), .AW(AW), .TW(TW), .IW(IW)) u_arith (
    .op_i       (op),
    .a_i        (opnd_a_i),
    .b_i        (opnd_b_i),
    .addr_imm_i (addr_imm_i),
    .tag_imm_i  (tag_imm_i),
    .res_o      (arith_res),
    .flags_o    (arith_flags)
  );

  assign res_nxt = (op == OP_RAND)
                 ? {opnd_a_i[PW-1:TMSB+1], rand_tag, opnd_a_i[AW-1:0]}
                 : arith_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      flags_q     <= '0;
    end else begin
      res_valid_o <= fire;
      if (fire) res_data_o <= res_nxt;
      if (req_valid_i && op == OP_PSUBF) flags_q <= arith_flags;
    end
  end

  assign flags_o = flags_q;

  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> res_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !res_valid_o && $stable(res_data_o));
  a_r3_not_excluded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rand_req && !(&opnd_b_i[NT-1:0])) |-> !opnd_b_i[rand_tag]);
  a_r3_addr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rand_req |=> res_data_o[AW-1:0] == $past(opnd_a_i[AW-1:0]));
  a_r6_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op == OP_EXCL) |=> res_data_o[$past(opnd_a_i[TMSB:TLSB])]);
  a_r7_zero_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (op == OP_ADDT || op == OP_SUBT) && tag_imm_i == '0)
      |=> res_data_o[TMSB:TLSB] == $past(opnd_a_i[TMSB:TLSB]));
  a_r9_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (op == OP_PSUB || op == OP_PSUBF))
      |=> res_data_o[PW-1:AW] == {(PW-AW){res_data_o[AW-1]}});
  a_r11_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && op == OP_PSUBF) |=> $stable(flags_o));
endmodule

// File: tb/tagu_top_tb.sv
module tagu_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_op_i = '0;
  logic [63:0] opnd_a_i = '0, opnd_b_i = '0;
  logic [5:0]  addr_imm_i = '0;
  logic [3:0]  tag_imm_i = '0;
  logic        seed_load_i = 1'b0;
  logic [15:0] seed_i = '0;
  logic        free_run_i = 1'b0;
  logic        res_valid_o;
  logic [63:0] res_data_o;
  logic [3:0]  flags_o;

  int errors = 0, checks = 0, cycles = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  logic        e_valid = 1'b0;
  logic [63:0] e_data = '0;
  logic [3:0]  e_flags = '0;

  always #2 clk_i = ~clk_i;

  tagu_top u_dut (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [3:0] pick(input logic [3:0] c, input logic [15:0] m);
    for (int i = 0; i < 16; i++) begin
      int t = (int'(c) + i) % 16;
      if (!m[t]) return 4'(t);
    end
    return 4'd0;
  endfunction

  function automatic logic [15:0] lfsr_adv(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                      input logic [5:0] ai, input logic [3:0] ti, input logic ld, input logic [15:0] sd,
                      input logic fr, input string rq);
    logic [63:0] ex, ey, sa, sb;
    logic [55:0] d, ad;
    logic [3:0]  tg;
    longint      sr;
    req_valid_i = v; req_op_i = op; opnd_a_i = a; opnd_b_i = b;
    addr_imm_i = ai; tag_imm_i = ti; seed_load_i = ld; seed_i = sd; free_run_i = fr;
    e_valid = v && op <= 3'd5;
    if (e_valid) begin
      case (op)
        3'd0: e_data = {a[63:60], pick(m_lfsr[3:0], b[15:0]), a[55:0]};
        3'd1: begin ex = 64'(b[15:0]); ex[a[59:56]] = 1'b1; e_data = ex; end
        3'd2, 3'd3: begin
          if (op == 3'd2) begin ad = a[55:0] + 56'(ai) * 56'd16; tg = a[59:56] + ti; end
          else begin ad = a[55:0] - 56'(ai) * 56'd16; tg = a[59:56] - ti; end
          if (ti != 0) tg = pick(tg, b[15:0]); else tg = a[59:56];
          e_data = {a[63:60], tg, ad};
        end
        default: begin
          d = a[55:0] - b[55:0];
          e_data = {{8{d[55]}}, d};
          if (op == 3'd5) begin
            sa = {{8{a[55]}}, a[55:0]}; sb = {{8{b[55]}}, b[55:0]};
            sr = $signed(sa) - $signed(sb);
            e_flags = {sr < 0, sr == 0, sa >= sb, 1'b0};
          end
        end
      endcase
    end
    if (ld) m_lfsr = (sd == 0) ? 16'hACE1 : sd;
    else if ((v && op == 3'd0) || fr) m_lfsr = lfsr_adv(m_lfsr);
    @(posedge clk_i); @(negedge clk_i);
    chk(rq, 64'(res_valid_o), 64'(e_valid), "valid");
    chk(rq, res_data_o, e_data, "data");
    chk(rq, 64'(flags_o), 64'(e_flags), "flags");
  endtask

  task automatic idle(input int n, input logic fr);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, 0, 0, 0, 0, fr, "R2");
  endtask

  initial begin
    #1;
    @(negedge clk_i);
    chk("R1", {61'(res_valid_o), 3'b0}, 64'd0, "reset valid");
    chk("R1", res_data_o, 64'd0, "reset data");
    chk("R1", 64'(flags_o), 64'd0, "reset flags");
    @(negedge clk_i); rst_ni = 1'b1;
    // R3/R4 seeded sequence, various masks
    step(1, 0, 64'h5A00_1234_5678_9ABC, 64'h0, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 64'hF3FF_FFFF_FFFF_FFF0, 64'h00FF, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 64'h0123_4567_89AB_CDEF, 64'hFFFF, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 64'h0123_4567_89AB_CDEF, 64'hBFFF, 0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 20; i++)
      step(1, 0, {32'(i), 32'hCAFE_0000}, 64'(16'h1 << (i % 16)), 0, 0, 0, 0, 0, "R4");
    idle(3, 0);
    // R5 seed load, zero seed, replay
    step(0, 0, '0, '0, 0, 0, 1, 16'h0000, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 0, 64'h0, 64'h0, 0, 0, 0, 0, 0, "R5");
    step(1, 0, 64'h0, 64'h0, 0, 0, 1, 16'h1234, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 0, 64'h0, 64'h0, 0, 0, 0, 0, 0, "R5");
    // R4 free-running mode
    idle(7, 1);
    step(1, 0, 64'h0, 64'h0, 0, 0, 0, 0, 1, "R4");
    step(1, 0, 64'h0, 64'h0F0F, 0, 0, 0, 0, 1, "R4");
    // R6 exclusion add
    step(1, 1, 64'h0700_0000_0000_0000, 64'h0000_0000_0000_0001, 0, 0, 0, 0, 0, "R6");
    step(1, 1, 64'hFF00_0000_0000_0000, 64'hFFFF_FFFF_FFFF_0000, 0, 0, 0, 0, 0, "R6");
    // R7 tag add
    step(1, 2, 64'hA300_0000_0000_1000, 64'h0, 6'd5, 4'd0, 0, 0, 0, "R7");
    step(1, 2, 64'h5E00_FFFF_FFFF_FFF0, 64'h0, 6'd63, 4'd3, 0, 0, 0, "R7");
    step(1, 2, 64'h0200_0000_0000_0040, 64'h0038, 6'd1, 4'd1, 0, 0, 0, "R7");
    step(1, 2, 64'h0200_0000_0000_0040, 64'hFFFF, 6'd1, 4'd1, 0, 0, 0, "R7");
    // R8 tag subtract
    step(1, 3, 64'h1100_0000_0000_0000, 64'h0, 6'd1, 4'd2, 0, 0, 0, "R8");
    step(1, 3, 64'h0500_0000_0000_0400, 64'h0018, 6'd63, 4'd2, 0, 0, 0, "R8");
    // R9 pointer subtract, top bytes ignored
    step(1, 4, 64'hAB00_0000_0000_0100, 64'h3C00_0000_0000_0040, 0, 0, 0, 0, 0, "R9");
    step(1, 4, 64'h1200_0000_0000_0010, 64'hEE00_0000_0000_0020, 0, 0, 0, 0, 0, "R9");
    // R10 flags
    step(1, 5, 64'h0100_0000_0000_0500, 64'h0200_0000_0000_0500, 0, 0, 0, 0, 0, "R10");
    step(1, 5, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020, 0, 0, 0, 0, 0, "R10");
    step(1, 5, 64'h0080_0000_0000_0000, 64'h0000_0000_0000_0001, 0, 0, 0, 0, 0, "R10");
    step(1, 5, 64'h007F_FFFF_FFFF_FFFF, 64'h0080_0000_0000_0000, 0, 0, 0, 0, 0, "R10");
    // R11 flags hold across other ops; R2 invalid codes
    step(1, 4, 64'h5, 64'h9, 0, 0, 0, 0, 0, "R11");
    step(1, 6, 64'hDEAD, 64'hBEEF, 0, 0, 0, 0, 0, "R2");
    step(1, 7, 64'hDEAD, 64'hBEEF, 0, 0, 0, 0, 0, "R2");
    idle(2, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule